// File: doc/BRIEF.md
# Programmable-Priority Vectored Interrupt Controller

This block gathers twenty interrupt request lines and reduces them to one interrupt output and one vector word. Software gives most sources one of eight priority levels, where level 0 is the most urgent, through three priority registers on a small synchronous register bus. Every cycle the block picks the most urgent active request. It registers the result as a vector word made of a software-written base value, the winning source index and two zero bits. Interrupt service code can read that word and use it directly as a jump-table address.

Source 0 has no priority field. It is served only when nothing else is requesting. Sources 1 to 4 also have no field and sit at the fixed level 7. The other fifteen sources each own a 3-bit field. The output stage is a two-state machine. It moves from `ST_IDLE` to `ST_ASSERT` when any request is present, stays in `ST_ASSERT` while requests remain, and returns to `ST_IDLE` when the last request drops. `irq_out` is high exactly in `ST_ASSERT`.

Top module: `prio_vic`

## Requirements
- R1: After reset, all priority registers and the base register read zero, `irq_out` is low and the vector word is zero.
- R2: Priority registers sit at byte offsets 0x20, 0x24 and 0x28. They are read/write, but only their field bits hold data. The implemented masks are 0x07777070, 0x77777700 and 0x00007777. All other bits read as zero and ignore writes.
- R3: Among active sources, the one with the numerically smallest level wins. Level 0 is the most urgent.
- R4: When several active sources share the best level, the one with the lowest index wins.
- R5: Source 0 is reported only when it is the sole active request. Any other active source beats it, whatever that source's level.
- R6: Sources 1, 2, 3 and 4 have no priority field and compete at the fixed level 7.
- R7: The vector word is {9'b0, base[15:0], index[4:0], 2'b00}. The base register is at offset 0x2C and keeps bits 15:0. The vector word is readable at offset 0x30 and is also driven on `vec_word`.
- R8: With no active request, `irq_out` is low and the index field is zero, while the base field stays as written.
- R9: `irq_out` and the index field show the request and priority state sampled at the previous rising clock edge, so they lag by exactly one clock.
- R10: Writes to the vector offset 0x30 have no effect.
- R11: Field positions by source index, given as register offset and bits:
  - 0x20: 5 at 6:4, 7 at 14:12, 8 at 18:16, 9 at 22:20, 10 at 26:24
  - 0x24: 11 at 10:8, 12 at 14:12, 13 at 18:16, 14 at 22:20, 15 at 26:24, 6 at 30:28
  - 0x28: 16 at 2:0, 17 at 6:4, 18 at 10:8, 19 at 14:12
- R12: A bus read with `bus_sel` high and `bus_wr` low returns its data on `bus_rdata` one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_req | input | 20 | Raw request lines, active high, one per source |
| irq_out | output | 1 | Combined interrupt request |
| vec_word | output | 32 | Current vector word |

## Verification
The bench builds the block with its default parameters: twenty sources, 3-bit levels and a 16-bit base. At that size every field position in the map, the fixed-level sources 1 to 4 and the full 5-bit index range up to 19 can all be reached. The chosen stimuli set up level wins, same-level ties across registers, ties between a fixed source and a programmed level 7, and source 0 alone and in company. Together these cover each ordering rule at its boundary.

// File: rtl/prio_vic_pkg.sv
package prio_vic_pkg;

    localparam int MAP_SRC    = 20;
    localparam int NUM_PREG   = 3;
    localparam int FIXED_LVL  = 7;

    localparam logic [7:0] OFF_PRIO0 = 8'h20;
    localparam logic [7:0] OFF_PRIO1 = 8'h24;
    localparam logic [7:0] OFF_PRIO2 = 8'h28;
    localparam logic [7:0] OFF_BASE  = 8'h2C;
    localparam logic [7:0] OFF_VEC   = 8'h30;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ASSERT = 1'b1
    } vic_state_e;

    // Register number holding the level of a source, or -1 when none.
    function automatic int fld_reg(input int idx);
        case (idx)
            5, 7, 8, 9, 10:          return 0;
            6, 11, 12, 13, 14, 15:   return 1;
            16, 17, 18, 19:          return 2;
            default:                 return -1;
        endcase
    endfunction

    // Least significant bit of the level field of a source.
    function automatic int fld_lsb(input int idx);
        case (idx)
            5:  return 4;
            6:  return 28;
            7:  return 12;
            8:  return 16;
            9:  return 20;
            10: return 24;
            11: return 8;
            12: return 12;
            13: return 16;
            14: return 20;
            15: return 24;
            16: return 0;
            17: return 4;
            18: return 8;
            19: return 12;
            default: return 0;
        endcase
    endfunction

    // Writable bits of one priority register, built from the field map.
    function automatic logic [31:0] preg_mask(input int r, input int lvl_w);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < MAP_SRC; i++) begin
            if (fld_reg(i) == r) begin
                for (int b = 0; b < lvl_w; b++) begin
                    m[fld_lsb(i) + b] = 1'b1;
                end
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/prio_vic_regs.sv
module prio_vic_regs
    import prio_vic_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int LVL_W  = 3,
    parameter int BASE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] vec_word,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] prio_q [NUM_PREG],
    output logic [BASE_W-1:0] base_q
);

    localparam logic [DATA_W-1:0] MASK0 = DATA_W'(preg_mask(0, LVL_W));
    localparam logic [DATA_W-1:0] MASK1 = DATA_W'(preg_mask(1, LVL_W));
    localparam logic [DATA_W-1:0] MASK2 = DATA_W'(preg_mask(2, LVL_W));

    logic              wr_en;
    logic              rd_en;
    logic [DATA_W-1:0] rd_mux;

    assign wr_en = bus_sel && bus_wr;
    assign rd_en = bus_sel && !bus_wr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_PREG; k++) begin
                prio_q[k] <= '0;
            end
            base_q <= '0;
        end else if (wr_en) begin
            case (bus_addr)
                ADDR_W'(OFF_PRIO0): prio_q[0] <= bus_wdata & MASK0;
                ADDR_W'(OFF_PRIO1): prio_q[1] <= bus_wdata & MASK1;
                ADDR_W'(OFF_PRIO2): prio_q[2] <= bus_wdata & MASK2;
                ADDR_W'(OFF_BASE):  base_q    <= bus_wdata[BASE_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (bus_addr)
            ADDR_W'(OFF_PRIO0): rd_mux = prio_q[0];
            ADDR_W'(OFF_PRIO1): rd_mux = prio_q[1];
            ADDR_W'(OFF_PRIO2): rd_mux = prio_q[2];
            ADDR_W'(OFF_BASE):  rd_mux = DATA_W'(base_q);
            ADDR_W'(OFF_VEC):   rd_mux = vec_word;
            default:            rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_en) begin
            bus_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/prio_vic_arb.sv
module prio_vic_arb
    import prio_vic_pkg::*;
#(
    parameter int NUM_SRC = 20,
    parameter int DATA_W  = 32,
    parameter int LVL_W   = 3,
    parameter int IDX_W   = 5
) (
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [DATA_W-1:0]  prio_q [NUM_PREG],
    output logic [IDX_W-1:0]   win_idx,
    output logic               win_any
);

    localparam int RANK_W = LVL_W + 1;

    logic [RANK_W-1:0] rank [NUM_SRC];

    // Source 0 ranks below every level; unmapped sources sit at a fixed level.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_rank
        localparam int RI = fld_reg(i);
        localparam int LI = fld_lsb(i);
        if (i == 0) begin : g_floor
            assign rank[i] = {1'b1, {LVL_W{1'b0}}};
        end else if (RI < 0) begin : g_fixed
            assign rank[i] = {1'b0, LVL_W'(FIXED_LVL)};
        end else begin : g_prog
            assign rank[i] = {1'b0, prio_q[RI][LI +: LVL_W]};
        end
    end

    always_comb begin
        logic [RANK_W-1:0] best;
        best    = '1;
        win_idx = '0;
        win_any = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (irq_req[i] && (!win_any || rank[i] < best)) begin
                best    = rank[i];
                win_idx = IDX_W'(i);
                win_any = 1'b1;
            end
        end
    end

endmodule

// File: rtl/prio_vic_vec.sv
module prio_vic_vec
    import prio_vic_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5,
    parameter int BASE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_any,
    input  logic [IDX_W-1:0]  win_idx,
    input  logic [BASE_W-1:0] base_q,
    output logic              irq_out,
    output logic [DATA_W-1:0] vec_word
);

    localparam int PAD_W = DATA_W - BASE_W - IDX_W - 2;

    vic_state_e       state_q;
    vic_state_e       state_d;
    logic [IDX_W-1:0] idx_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = win_any ? ST_ASSERT : ST_IDLE;
            ST_ASSERT: state_d = win_any ? ST_ASSERT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else begin
            idx_q <= win_any ? win_idx : '0;
        end
    end

    assign irq_out  = (state_q == ST_ASSERT);
    assign vec_word = {{PAD_W{1'b0}}, base_q, idx_q, 2'b00};

endmodule

// File: rtl/prio_vic.sv
module prio_vic
    import prio_vic_pkg::*;
#(
    parameter int NUM_SRC = 20,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8,
    parameter int LVL_W   = 3,
    parameter int BASE_W  = 16,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] irq_req,
    output logic               irq_out,
    output logic [DATA_W-1:0]  vec_word
);

    logic [DATA_W-1:0] prio_q [NUM_PREG];
    logic [BASE_W-1:0] base_q;
    logic [IDX_W-1:0]  win_idx;
    logic              win_any;

    prio_vic_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .LVL_W  (LVL_W),
        .BASE_W (BASE_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .vec_word  (vec_word),
        .bus_rdata (bus_rdata),
        .prio_q    (prio_q),
        .base_q    (base_q)
    );

    prio_vic_arb #(
        .NUM_SRC (NUM_SRC),
        .DATA_W  (DATA_W),
        .LVL_W   (LVL_W),
        .IDX_W   (IDX_W)
    ) u_arb (
        .irq_req (irq_req),
        .prio_q  (prio_q),
        .win_idx (win_idx),
        .win_any (win_any)
    );

    prio_vic_vec #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W),
        .BASE_W (BASE_W)
    ) u_vec (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_any  (win_any),
        .win_idx  (win_idx),
        .base_q   (base_q),
        .irq_out  (irq_out),
        .vec_word (vec_word)
    );

endmodule

// File: rtl/prio_vic_chk.sv
module prio_vic_chk
    import prio_vic_pkg::*;
#(
    parameter int NUM_SRC = 20,
    parameter int DATA_W  = 32,
    parameter int LVL_W   = 3,
    parameter int BASE_W  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] irq_req,
    input logic               irq_out,
    input logic [DATA_W-1:0]  vec_word,
    input logic [DATA_W-1:0]  prio_q [NUM_PREG]
);

    localparam int IDX_W = $clog2(NUM_SRC);
    localparam int TOP_B = BASE_W + IDX_W + 2;

    logic [IDX_W-1:0] vidx;
    assign vidx = vec_word[IDX_W+1:2];

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req == '0) |=> (!irq_out && vidx == '0));

    // R9
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req != '0) |=> irq_out);

    // R7
    vec_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_word[1:0] == 2'b00) && (vec_word[DATA_W-1:TOP_B] == '0));

    // R5
    floor_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req[0] && irq_req[NUM_SRC-1:1] == '0) |=> (irq_out && vidx == '0));

    // R5
    floor_beaten_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req[NUM_SRC-1:1] != '0) |=> (vidx != '0));

    // R3
    winner_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (($past(irq_req) >> vidx) & 1) == 1);

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((prio_q[0] & ~DATA_W'(preg_mask(0, LVL_W))) == '0) &&
        ((prio_q[1] & ~DATA_W'(preg_mask(1, LVL_W))) == '0) &&
        ((prio_q[2] & ~DATA_W'(preg_mask(2, LVL_W))) == '0));

endmodule

bind prio_vic prio_vic_chk #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W),
    .LVL_W   (LVL_W),
    .BASE_W  (BASE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_req  (irq_req),
    .irq_out  (irq_out),
    .vec_word (vec_word),
    .prio_q   (prio_q)
);

// File: tb/prio_vic_bench.sv
`timescale 1ns/1ps
module prio_vic_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [19:0] irq_req = '0;
    logic        irq_out;
    logic [31:0] vec_word;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] vec;
        logic        irq;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    prio_vic u_prio_vic (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_req   (irq_req),
        .irq_out   (irq_out),
        .vec_word  (vec_word)
    );

    logic [15:0] base_m = '0;

    function automatic logic [31:0] mk_vec(input logic [15:0] b, input int idx);
        return {9'b0, b, 5'(idx), 2'b00};
    endfunction

    // Monitor: pops expected items and compares with the ports.
    always @(negedge clk) begin
        #1;
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (vec_word !== e.vec || irq_out !== e.irq) begin
                fails++;
                $display("FAIL %s vec=%h irq=%b expected vec=%h irq=%b",
                         e.tag, vec_word, irq_out, e.vec, e.irq);
            end
        end
    end

    task automatic expect_out(input int idx, input logic irq, input string tag);
        exp_t e;
        e.vec = mk_vec(base_m, idx);
        e.irq = irq;
        e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_check(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        checks++;
        if (bus_rdata !== exp) begin
            fails++;
            $display("FAIL %s addr=%h read=%h expected=%h", tag, a, bus_rdata, exp);
        end
    endtask

    // Apply requests, one edge later the registered outputs follow (R9).
    task automatic set_req(input logic [19:0] r);
        @(negedge clk);
        irq_req = r;
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        end
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        expect_out(0, 1'b0, "R1 reset outputs");
        bus_check(8'h20, 32'h0, "R1 prio0 reset");
        bus_check(8'h24, 32'h0, "R1 prio1 reset");
        bus_check(8'h28, 32'h0, "R1 prio2 reset");
        bus_check(8'h2C, 32'h0, "R1 base reset");

        // R2 masks, R12 read latency
        bus_write(8'h20, 32'hFFFF_FFFF);
        bus_check(8'h20, 32'h0777_7070, "R2 prio0 mask");
        bus_write(8'h24, 32'hFFFF_FFFF);
        bus_check(8'h24, 32'h7777_7700, "R2 prio1 mask");
        bus_write(8'h28, 32'hFFFF_FFFF);
        bus_check(8'h28, 32'h0000_7777, "R2 R12 prio2 mask");
        bus_write(8'h20, 32'h0);
        bus_write(8'h24, 32'h0);
        bus_write(8'h28, 32'h0);

        // R7 base register and vector layout
        bus_write(8'h2C, 32'hFFFF_ABCD);
        base_m = 16'hABCD;
        bus_check(8'h2C, 32'h0000_ABCD, "R7 base keep low half");
        bus_check(8'h30, mk_vec(base_m, 0), "R7 R8 vector idle read");

        // R4 tie at level 0: 8 vs 12, lower index wins; R11 index 8
        set_req(20'h0_1100);
        expect_out(8, 1'b1, "R4 R11 tie low index");
        bus_check(8'h30, mk_vec(base_m, 8), "R7 vector read index 8");

        // R3 level beats index: idx12 level 0, idx8 level 3 (0x20 bits 18:16)
        bus_write(8'h20, 32'h0003_0000);
        @(negedge clk);
        expect_out(12, 1'b1, "R3 R11 level wins");

        // R11 idx6 at 0x24 bits 30:28 level 1 vs idx12 level 2
        bus_write(8'h24, 32'h1000_2000);
        set_req(20'h0_1040);
        expect_out(6, 1'b1, "R11 idx6 field");

        // R5 source 0 alone
        set_req(20'h0_0001);
        expect_out(0, 1'b1, "R5 floor alone");

        // R5 R6 fixed source 3 beats source 0
        set_req(20'h0_0009);
        expect_out(3, 1'b1, "R5 R6 fixed beats floor");

        // R6 fixed idx2 vs idx19 programmed 7: tie, idx2 wins
        bus_write(8'h28, 32'h0000_7000);
        set_req(20'h8_0004);
        expect_out(2, 1'b1, "R6 fixed tie");

        // R6 idx19 at level 6 beats fixed level 7
        bus_write(8'h28, 32'h0000_6000);
        @(negedge clk);
        expect_out(19, 1'b1, "R6 R11 programmed beats fixed");

        // R10 write to vector offset ignored
        bus_write(8'h30, 32'h0000_0000);
        bus_check(8'h30, mk_vec(base_m, 19), "R10 vector read only");
        expect_out(19, 1'b1, "R10 vector port unchanged");

        // R8 all requests dropped
        set_req(20'h0);
        expect_out(0, 1'b0, "R8 idle");

        // R9 one-clock latency: check right after the single edge
        @(negedge clk);
        irq_req = 20'h0_0100;
        @(negedge clk);
        expect_out(8, 1'b1, "R9 one clock latency");

        set_req(20'h0);
        expect_out(0, 1'b0, "R8 idle again");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        end
        $finish;
    end

endmodule